// File: doc/BRIEF.md
# RDS block synchronization controller

This block follows block framing on a radio data stream that is carried in 26-bit blocks. An upstream syndrome stage sends one event for each received block. The event carries the offset-word code that was detected, or a "none" code, and a flag that marks the block as uncorrectable. From these events the controller decides when framing is acquired and when it is lost. It reports the offset it expects for the next block. It also tags every processed block with an offset code and a flag. The flag tells whether that offset was actually seen or was only filled in by the flywheel.

Configuration inputs set the acquisition and loss rules:

- Acquisition can require two correctly ordered offsets within three blocks, or in two consecutive blocks.
- Loss of lock follows a run of failing blocks. The run length comes from an encoded threshold.
- A "failing" block means either a missing correct-order offset or an uncorrectable block, as selected.

A synchronous clear input drops the lock and holds capture off until it is released.

Top module: `rds_block_sync`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets. After that edge `locked` is 0, `out_valid` is 0 and `next_offset` is 3'b111 (no expectation).
- R2: Offset codes are A=000, B=001, C=010, C'=011, D=100 and E=101. Codes 110 and 111 mean no offset. The cyclic order is A, B, C-or-C', D, A. While locked, an offset that arrives in this order is reported with `out_detected`=1 and its own code, so C' is accepted in the C slot.
- R3: With `cfg_acq_mode`=0, lock is declared on a correct-order offset that arrives one or two blocks after a previous detection. The block in between may have no offset. After a gap of two offset-less blocks the reference is discarded.
- R4: With `cfg_acq_mode`=1, lock needs correct-order offsets in two consecutive blocks. A single offset-less block in between discards the reference.
- R5: `cfg_loss_code` selects how many consecutive failing blocks cause loss of lock. Codes 0 to 7 (bit 0 is the LSB) give 3, 4, 5, 6, 8, 10, 12 and 16 blocks. The block that completes the run already shows `locked`=0.
- R6: With `cfg_loss_on_err`=0, a locked block fails when its correct-order offset is absent. With `cfg_loss_on_err`=1, a locked block fails only when `blk_uncorr` is 1.
- R7: Code E is recognized only when `cfg_rbds_en`=1. It is then reported as code 101 with `out_detected`=1. Otherwise it is handled as "no offset" and is never reported as detected.
- R8: While `sync_clear` is 1, the block is unlocked, has no expectation (`next_offset`=111), and ignores blocks (`out_valid`=0). Capture starts afresh with the first block after release.
- R9: While locked, a block without its correct-order offset is reported with the expected code and `out_detected`=0. A flywheeled C slot reports 010.
- R10: The failure run counter clears on every passing block and starts from zero on entry to lock.
- R11: `out_valid` is asserted exactly one clock after each accepted `blk_valid`. `locked` and `next_offset` change in the same cycle. While unlocked, a block with no offset reports code 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_clear | input | 1 | Forces unsynchronized state; capture restarts on release |
| cfg_acq_mode | input | 1 | 0: two of three blocks, 1: two consecutive blocks |
| cfg_loss_code | input | 3 | Encoded loss threshold (3..16 blocks) |
| cfg_loss_on_err | input | 1 | 0: count missing offsets, 1: count uncorrectable blocks |
| cfg_rbds_en | input | 1 | Enables recognition of offset E |
| blk_valid | input | 1 | One received block event |
| blk_offset | input | 3 | Detected offset code, 110/111 for none |
| blk_uncorr | input | 1 | Block was uncorrectable |
| locked | output | 1 | Block synchronization established |
| next_offset | output | 3 | Offset expected for the next block, 111 if none |
| out_valid | output | 1 | Report for the previous block is valid |
| out_offset | output | 3 | Offset code assigned to the reported block |
| out_detected | output | 1 | 1 if seen, 0 if flywheeled (or absent when unlocked) |

## Verification
The bench checks three corner cases that a wrong design would get visibly wrong:

- **Threshold run.** For every loss code the bench drives exactly the threshold number of failing blocks. A design off by one on the run would drop lock one block early, or stay locked one block too long.
- **Acquisition window.** The bench checks the two-of-three window against the strict consecutive mode. A design that lets the window stretch, or ignores the mode, locks on the gap pattern in the wrong mode.
- **Other cases.** The bench also checks that C' is accepted in the C slot, that E is suppressed without the RBDS enable, that only uncorrectable blocks count under the error criterion, and that a passing block in the middle of a run resets the count. Errors in these show up as wrong codes, false detections or early loss of lock.

A long biased random stream then mixes all of these, with configuration changes in the middle of the stream.

// File: rtl/rbs_pkg.sv
// Shared types and tables for the RDS block synchronization controller.
// Assumes 3-bit offset codes, with the cyclic slots A, B, C/C', D in that order.
package rbs_pkg;
    typedef logic [2:0] ofs_code_t;
    typedef logic [1:0] slot_t;

    localparam ofs_code_t OFS_A    = 3'd0;
    localparam ofs_code_t OFS_B    = 3'd1;
    localparam ofs_code_t OFS_C    = 3'd2;
    localparam ofs_code_t OFS_CP   = 3'd3;
    localparam ofs_code_t OFS_D    = 3'd4;
    localparam ofs_code_t OFS_E    = 3'd5;
    localparam ofs_code_t OFS_NONE = 3'd7;

    localparam int MAX_LOSS = 16;
    localparam int LOSS_W   = $clog2(MAX_LOSS + 1);
    typedef logic [LOSS_W-1:0] loss_t;

    // Code reported for a slot position when the offset is flywheeled.
    function automatic ofs_code_t slot_code(slot_t s);
        case (s)
            2'd0:    return OFS_A;
            2'd1:    return OFS_B;
            2'd2:    return OFS_C;
            default: return OFS_D;
        endcase
    endfunction

    // Number of consecutive failing blocks that ends lock, per encoded setting.
    function automatic loss_t loss_limit(logic [2:0] c);
        case (c)
            3'd0:    return loss_t'(3);
            3'd1:    return loss_t'(4);
            3'd2:    return loss_t'(5);
            3'd3:    return loss_t'(6);
            3'd4:    return loss_t'(8);
            3'd5:    return loss_t'(10);
            3'd6:    return loss_t'(12);
            default: return loss_t'(MAX_LOSS);
        endcase
    endfunction
endpackage

// File: rtl/rbs_offset_classify.sv
// Classifies a detected offset code. It tells whether the code belongs to the
// A/B/C/C'/D cycle, which slot it occupies, and whether it is a recognized
// offset E. Purely combinational. Codes 110 and 111 mean no offset.
module rbs_offset_classify
    import rbs_pkg::*;
(
    input  ofs_code_t code,
    input  logic      rbds_en,
    output logic      is_cyc,
    output slot_t     slot,
    output logic      is_e
);
    // Decode the code into cycle membership, slot position and E recognition.
    always_comb begin
        is_cyc = (code <= OFS_D);
        is_e   = (code == OFS_E) && rbds_en;
        case (code)
            OFS_A:         slot = 2'd0;
            OFS_B:         slot = 2'd1;
            OFS_C, OFS_CP: slot = 2'd2;
            default:       slot = 2'd3;
        endcase
    end
endmodule

// File: rtl/rbs_loss_counter.sv
// Counts consecutive failing blocks while locked. It raises 'lost' combinationally
// on the block that completes the configured run. Assumes the caller holds
// 'clear' high whenever the block is not locked.
module rbs_loss_counter
    import rbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    input  logic       fail,
    input  logic [2:0] loss_code,
    output logic       lost
);
    loss_t           cnt;
    loss_t           limit;
    logic [LOSS_W:0] cnt_inc;

    assign limit   = loss_limit(loss_code);
    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign lost    = step && fail && (cnt_inc >= {1'b0, limit});

    // Run counter: grows on failing blocks, clears on pass, on loss and when cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (fail && !lost) ? cnt_inc[LOSS_W-1:0] : '0;
        end
    end

    AST_CNT_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) < MAX_LOSS); // R5
    AST_PASS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        step && !fail |=> cnt == '0); // R10
endmodule

// File: rtl/rbs_slot_tracker.sv
// Holds the expected slot position. While unlocked it also holds the
// acquisition reference: a detected offset sets the expectation to its
// successor, and one offset-less gap is allowed in two-of-three mode.
// Asserts 'acq_hit' when an unlocked block matches the reference.
module rbs_slot_tracker
    import rbs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  step,
    input  logic  locked,
    input  logic  acq_mode,
    input  logic  is_cyc,
    input  slot_t slot,
    output slot_t exp_slot,
    output logic  ref_valid,
    output logic  acq_hit
);
    logic gap_used;

    assign acq_hit = step && !locked && is_cyc && ref_valid && (slot == exp_slot);

    // Advance the expectation per block; seed, stretch or drop the acquisition reference.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            exp_slot  <= '0;
            ref_valid <= 1'b0;
            gap_used  <= 1'b0;
        end else if (step) begin
            if (locked) begin
                exp_slot  <= exp_slot + 2'd1;
                ref_valid <= 1'b0;
                gap_used  <= 1'b0;
            end else if (is_cyc) begin
                exp_slot  <= slot + 2'd1;
                ref_valid <= !acq_hit;
                gap_used  <= 1'b0;
            end else if (ref_valid && !acq_mode && !gap_used) begin
                exp_slot  <= exp_slot + 2'd1;
                gap_used  <= 1'b1;
            end else begin
                ref_valid <= 1'b0;
                gap_used  <= 1'b0;
            end
        end
    end

    AST_GAP_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        gap_used |-> ref_valid); // R3
    AST_CONSEC_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !locked && !is_cyc && acq_mode && !clear |=> !ref_valid); // R4
endmodule

// File: rtl/rds_block_sync.sv
// RDS/RBDS block synchronization controller. It takes one event per received
// block and decides acquisition and loss of framing. It reports the expected
// next offset and registers a per-block report one clock after each event.
// Assumes at most one block event per clock, and quasi-static configuration.
module rds_block_sync
    import rbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_clear,
    input  logic       cfg_acq_mode,
    input  logic [2:0] cfg_loss_code,
    input  logic       cfg_loss_on_err,
    input  logic       cfg_rbds_en,
    input  logic       blk_valid,
    input  logic [2:0] blk_offset,
    input  logic       blk_uncorr,
    output logic       locked,
    output logic [2:0] next_offset,
    output logic       out_valid,
    output logic [2:0] out_offset,
    output logic       out_detected
);
    logic      step;
    logic      cls_cyc;
    logic      cls_e;
    slot_t     cls_slot;
    slot_t     exp_slot;
    logic      ref_valid;
    logic      acq_hit;
    logic      lost;
    logic      match;
    logic      blk_fail;
    logic      det_n;
    ofs_code_t ofs_n;

    assign step = blk_valid && !sync_clear;

    rbs_offset_classify i_classify (
        .code    (blk_offset),
        .rbds_en (cfg_rbds_en),
        .is_cyc  (cls_cyc),
        .slot    (cls_slot),
        .is_e    (cls_e)
    );

    rbs_slot_tracker i_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sync_clear),
        .step      (step),
        .locked    (locked),
        .acq_mode  (cfg_acq_mode),
        .is_cyc    (cls_cyc),
        .slot      (cls_slot),
        .exp_slot  (exp_slot),
        .ref_valid (ref_valid),
        .acq_hit   (acq_hit)
    );

    rbs_loss_counter i_loss (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sync_clear || !locked),
        .step      (step),
        .fail      (blk_fail),
        .loss_code (cfg_loss_code),
        .lost      (lost)
    );

    // Judge the current block and form its report code and detection flag.
    always_comb begin
        match    = cls_cyc && (cls_slot == exp_slot);
        blk_fail = cfg_loss_on_err ? blk_uncorr : !match;
        if (locked) begin
            det_n = match || cls_e;
            ofs_n = match ? blk_offset : (cls_e ? OFS_E : slot_code(exp_slot));
        end else begin
            det_n = cls_cyc || cls_e;
            ofs_n = cls_cyc ? blk_offset : (cls_e ? OFS_E : OFS_NONE);
        end
    end

    assign next_offset = (locked || ref_valid) ? slot_code(exp_slot) : OFS_NONE;

    // Lock state and the registered per-block report.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_clear) begin
            locked       <= 1'b0;
            out_valid    <= 1'b0;
            out_offset   <= OFS_NONE;
            out_detected <= 1'b0;
        end else begin
            out_valid <= step;
            if (step) begin
                out_offset   <= ofs_n;
                out_detected <= det_n;
                if (!locked && acq_hit) begin
                    locked <= 1'b1;
                end else if (locked && lost) begin
                    locked <= 1'b0;
                end
            end
        end
    end

    AST_CLEAR_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clear |=> !locked && !out_valid); // R8
    AST_LOCK_ON_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> out_valid && out_detected); // R3
    AST_FLYWHEEL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && locked && $past(locked) && !out_detected
        |-> out_offset == $past(next_offset)); // R9
    AST_E_NEEDS_RBDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_offset == OFS_E |-> $past(cfg_rbds_en)); // R7
    AST_REPORT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid && !sync_clear |=> out_valid); // R11
endmodule

// File: tb/test_rds_block_sync.sv
// Self-checking bench with a behavioural per-clock reference model.
module test_rds_block_sync;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_clear = 1'b0;
    logic       cfg_acq_mode = 1'b0;
    logic [2:0] cfg_loss_code = 3'd2;
    logic       cfg_loss_on_err = 1'b0;
    logic       cfg_rbds_en = 1'b0;
    logic       blk_valid = 1'b0;
    logic [2:0] blk_offset = 3'd7;
    logic       blk_uncorr = 1'b0;
    logic       locked;
    logic [2:0] next_offset;
    logic       out_valid;
    logic [2:0] out_offset;
    logic       out_detected;

    always #4 clk = ~clk;

    rds_block_sync i_rds_block_sync (.*);

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 0;

    // settings applied at the next step
    bit n_rst = 0, n_clr = 0, n_mode = 0, n_err = 0, n_rbds = 0;
    int n_code = 2;

    // reference model
    int order[4] = '{0, 1, 2, 4};
    int thr_tab[8] = '{3, 4, 5, 6, 8, 10, 12, 16};
    int m_lock = 0, m_refv = 0, m_gap = 0, m_exp = 0, m_cnt = 0;
    int m_ov = 0, m_det = 0, m_ofs = 7;

    function automatic int m_next();
        return (m_lock || m_refv) ? order[m_exp] : 7;
    endfunction

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("locked", int'(locked), m_lock);
        chk("next_offset", int'(next_offset), m_next());
        chk("out_valid", int'(out_valid), m_ov);
        if (m_ov != 0) begin
            chk("out_detected", int'(out_detected), m_det);
            chk("out_offset", int'(out_offset), m_ofs);
        end
    endtask

    task automatic model_update();
        int  c, p;
        bit  cyc, e, match, failb;
        c   = int'(blk_offset);
        cyc = (c <= 4);
        p   = (c == 0) ? 0 : (c == 1) ? 1 : (c <= 3) ? 2 : 3;
        e   = (c == 5) && cfg_rbds_en;
        if (!rst_n || sync_clear) begin
            m_lock = 0; m_refv = 0; m_gap = 0; m_exp = 0; m_cnt = 0; m_ov = 0;
        end else if (!blk_valid) begin
            m_ov = 0;
        end else begin
            m_ov = 1;
            if (m_lock != 0) begin
                match = cyc && (p == m_exp);
                m_det = (match || e) ? 1 : 0;
                m_ofs = match ? c : (e ? 5 : order[m_exp]);
                failb = cfg_loss_on_err ? blk_uncorr : !match;
                if (failb) begin
                    m_cnt++;
                    if (m_cnt >= thr_tab[cfg_loss_code]) begin
                        m_lock = 0; m_cnt = 0;
                    end
                end else begin
                    m_cnt = 0;
                end
                m_exp = (m_exp + 1) % 4; m_refv = 0; m_gap = 0;
            end else begin
                m_det = (cyc || e) ? 1 : 0;
                m_ofs = cyc ? c : (e ? 5 : 7);
                if (cyc) begin
                    if (m_refv != 0 && p == m_exp) begin
                        m_lock = 1; m_refv = 0; m_cnt = 0;
                    end else begin
                        m_refv = 1;
                    end
                    m_exp = (p + 1) % 4; m_gap = 0;
                end else if (m_refv != 0 && !cfg_acq_mode && m_gap == 0) begin
                    m_gap = 1; m_exp = (m_exp + 1) % 4;
                end else begin
                    m_refv = 0; m_gap = 0;
                end
            end
        end
    endtask

    task automatic step(bit v, int c, bit u);
        @(negedge clk);
        compare();
        rst_n = n_rst; sync_clear = n_clr; cfg_acq_mode = n_mode;
        cfg_loss_code = 3'(n_code); cfg_loss_on_err = n_err; cfg_rbds_en = n_rbds;
        blk_valid = v; blk_offset = 3'(c); blk_uncorr = u;
        model_update();
    endtask

    task automatic blk(int c);
        step(1, c, 0);
    endtask

    task automatic expected_blk(bit u);
        step(1, (m_next() == 7) ? 0 : m_next(), u);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 7, 0);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        idle(3);
        n_rst = 1;
        idle(2);
        // R3: two-of-three acquisition with one gap
        tag = "R3";
        blk(0); blk(7); blk(2);
        // R2: cyclic order with C' accepted
        tag = "R2";
        blk(4); blk(0); blk(1); blk(3); blk(4); blk(0); blk(1); blk(2); blk(4);
        // R9: flywheel while locked (4 misses under threshold 5)
        tag = "R9";
        for (int i = 0; i < 4; i++) blk(7);
        // R10: passing block clears the run
        tag = "R10";
        expected_blk(0);
        for (int i = 0; i < 4; i++) blk(7);
        expected_blk(0);
        // R5: the run of exactly five drops lock
        tag = "R5";
        for (int i = 0; i < 5; i++) blk(7);
        for (int k = 0; k < 8; k++) begin
            n_code = k;
            idle(1);
            blk(0); blk(1);
            for (int i = 0; i < thr_tab[k] + 1; i++) blk(7);
        end
        n_code = 2;
        // R6: uncorrectable criterion
        tag = "R6";
        n_err = 1;
        idle(1);
        blk(1); blk(2);
        for (int i = 0; i < 7; i++) blk(7);
        for (int i = 0; i < 5; i++) expected_blk(1);
        n_err = 0;
        // R4: consecutive mode rejects the gap pattern
        tag = "R4";
        n_mode = 1;
        idle(1);
        blk(0); blk(7); blk(2); blk(7); blk(4); blk(0);
        // R3: two gaps are too many in mode 0
        tag = "R3";
        n_clr = 1; idle(1); n_clr = 0;
        n_mode = 0;
        idle(1);
        blk(0); blk(7); blk(7); blk(3); blk(7); blk(4);
        // R7: E recognition only with the RBDS enable
        tag = "R7";
        blk(5); blk(5); blk(6);
        n_rbds = 1;
        blk(5); expected_blk(0); blk(5);
        n_rbds = 0;
        blk(5);
        // R8: clear while locked ignores blocks, then capture restarts
        tag = "R8";
        blk(0); blk(1);
        n_clr = 1;
        blk(2); blk(4); blk(0);
        n_clr = 0;
        blk(2); blk(4);
        // R11: gapped events
        tag = "R11";
        blk(0); idle(2); blk(1); idle(1); blk(7); blk(2); idle(3);
        // random mix
        tag = "R2 random";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 2) n_code = $urandom_range(0, 7);
            else if (r < 3) n_mode = ~n_mode;
            else if (r < 4) n_err = ~n_err;
            else if (r < 5) n_rbds = ~n_rbds;
            n_clr = ($urandom_range(0, 199) == 0);
            if ($urandom_range(0, 9) < 7) expected_blk(1'($urandom_range(0, 1)));
            else step(1'($urandom_range(0, 5) != 0), $urandom_range(0, 7), 1'($urandom_range(0, 1)));
        end
        n_clr = 0;
        idle(2);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule